// File: doc/BRIEF.md
# Frame Store Access Arbiter with Double Buffering

This block sits in front of the single port of a frame store and decides, on every cycle that the port can accept a transaction, which of three masters uses it. The display read-out master feeds the screen in real time, so it wins whenever it asks. A processor and a drawing engine split whatever cycles remain between them in strict alternation whenever both are waiting. Each master has a request and grant pair. A grant covers exactly one memory transaction and is given in the same cycle that the port accepts it.

The block also handles double buffering. Two base addresses are fixed by parameters. One region is the front buffer that the display reads. The other is the back buffer that the drawing engine writes. The display and the drawing engine give offsets, and the block adds the matching base to each. The processor gives full addresses. A swap request is held until the next rising edge of vertical blanking. At that edge the two regions trade roles, and a one-cycle done pulse reports the swap.

Top module: `fb_store_arbiter`

## Requirements
- R1: When `mem_ready` is high and `disp_req` is high, `disp_gnt` is high and no other grant is high in that cycle.
- R2: When `mem_ready` is low, no grant is high. In every cycle at most one grant is high, and `mem_req` is high exactly when a grant is high.
- R3: When `mem_ready` is high, `disp_req` is low and exactly one of the processor and drawing-engine requests is high, that requester is granted in the same cycle.
- R4: When `mem_ready` is high, `disp_req` is low and both background requests are high, the grant goes to the background master that was not granted most recently. After reset the processor counts as the one to go first.
- R5: In a display grant cycle, `mem_we` is 0 and `mem_addr` equals the front buffer base plus `disp_off`, modulo 2^ADDR_W. The front base is BASE0 when `front_sel` is 0 and BASE1 when it is 1.
- R6: In a drawing grant cycle, `mem_we` is 1, `mem_wdata` equals `drw_wdata`, and `mem_addr` equals the back buffer base plus `drw_off`, modulo 2^ADDR_W. The back base is BASE1 when `front_sel` is 0 and BASE0 when it is 1.
- R7: In a processor grant cycle, `mem_addr`, `mem_we` and `mem_wdata` equal `cpu_addr`, `cpu_we` and `cpu_wdata`.
- R8: A `swap_req` pulse is remembered. `front_sel` does not change in any cycle other than the one that follows a rising edge of `vblank` while a swap is pending.
- R9: On the clock edge where `vblank` is high for the first time after being low, a pending or same-cycle swap request inverts `front_sel`, raises `swap_done` for exactly one cycle and clears the pending request.
- R10: A swap request that arrives while `vblank` is already high waits for the next rising edge. A rising edge with no request pending leaves `front_sel` unchanged and does not raise `swap_done`.
- R11: While `rst_n` is low, all grants are low. After a reset, `front_sel` is 0, `swap_done` is 0 and no swap is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_ready | input | 1 | Memory port accepts a transaction this cycle |
| mem_req | output | 1 | A transaction is issued this cycle |
| mem_we | output | 1 | Issued transaction is a write |
| mem_addr | output | ADDR_W | Issued address |
| mem_wdata | output | DATA_W | Issued write data |
| disp_req | input | 1 | Display read request |
| disp_off | input | ADDR_W | Display offset within the front buffer |
| disp_gnt | output | 1 | Display read accepted |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | ADDR_W | Processor absolute address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_gnt | output | 1 | Processor transaction accepted |
| drw_req | input | 1 | Drawing engine write request |
| drw_off | input | ADDR_W | Drawing offset within the back buffer |
| drw_wdata | input | DATA_W | Drawing write data |
| drw_gnt | output | 1 | Drawing write accepted |
| vblank | input | 1 | Vertical blanking level from display timing |
| swap_req | input | 1 | Request a front/back buffer swap |
| swap_done | output | 1 | One-cycle pulse when the swap takes effect |
| front_sel | output | 1 | Which base is the front buffer (0: BASE0, 1: BASE1) |

## Verification
The bench targets cycles where the display and both background masters request together. An arbiter with the wrong priority would let a background master take a display slot. A broken alternation would hand the processor two slots in a row while the drawing engine waits. It also stresses stalled cycles: a design that ignores `mem_ready` would grant transactions that the port never accepts. On the swap side, it sends requests while `vblank` is already high and raises `vblank` with nothing pending. A level-triggered or unlatched swap would flip buffers in the middle of blanking or lose the request. The bench also checks that display and drawing addresses always land in opposite regions, which catches a swapped base selection.

// File: rtl/fsa_pkg.sv
// Package: shared source encoding for the frame store arbiter.
// Assumes: one winner per cycle at most; SRC_NONE means the port is idle.
package fsa_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DISP = 2'd1,
        SRC_CPU  = 2'd2,
        SRC_DRAW = 2'd3
    } fsa_src_e;
endpackage

// File: rtl/fsa_pick.sv
// Module: fsa_pick
// Chooses the winner for the current cycle. The display has absolute
// priority. Background masters alternate on a tie, steered by last_draw.
// Assumes: en low (reset) or rdy low forces no winner.
module fsa_pick
    import fsa_pkg::*;
(
    input  logic     en,
    input  logic     rdy,
    input  logic     disp_req,
    input  logic     cpu_req,
    input  logic     drw_req,
    input  logic     last_draw,
    output fsa_src_e win
);
    // Priority decision: display first, then round-robin between background masters
    always_comb begin
        win = SRC_NONE;
        if (en && rdy) begin
            if (disp_req)
                win = SRC_DISP;
            else if (cpu_req && drw_req)
                win = last_draw ? SRC_CPU : SRC_DRAW;
            else if (cpu_req)
                win = SRC_CPU;
            else if (drw_req)
                win = SRC_DRAW;
        end
    end
endmodule

// File: rtl/fsa_bufswap.sv
// Module: fsa_bufswap
// Holds the front-buffer select. A swap request is latched and applied on
// the first clock edge that sees vblank high after it was low.
// Assumes: vblank is synchronous to clk; synchronous active-low reset.
module fsa_bufswap (
    input  logic clk,
    input  logic rst_n,
    input  logic vblank,
    input  logic swap_req,
    output logic front_sel,
    output logic swap_done
);
    logic vb_q;
    logic pend_q;
    logic vb_rise;
    logic swap_now;

    // Edge detect and swap decision
    always_comb begin
        vb_rise  = vblank && !vb_q;
        swap_now = vb_rise && (pend_q || swap_req);
    end

    // State update: remember requests, flip on the edge, pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vb_q      <= 1'b0;
            pend_q    <= 1'b0;
            front_sel <= 1'b0;
            swap_done <= 1'b0;
        end else begin
            vb_q      <= vblank;
            pend_q    <= (pend_q || swap_req) && !swap_now;
            front_sel <= front_sel ^ swap_now;
            swap_done <= swap_now;
        end
    end
endmodule

// File: rtl/fsa_route.sv
// Module: fsa_route
// Steers the winning master's fields onto the memory port. Display and
// drawing offsets are relocated by the front and back bases.
// Assumes: address arithmetic wraps at ADDR_W bits.
module fsa_route
    import fsa_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  fsa_src_e          win,
    input  logic [ADDR_W-1:0] front_base,
    input  logic [ADDR_W-1:0] back_base,
    input  logic [ADDR_W-1:0] disp_off,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [ADDR_W-1:0] drw_off,
    input  logic [DATA_W-1:0] drw_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    // Port multiplexer driven by the winner
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (win)
            SRC_DISP: mem_addr = front_base + disp_off;
            SRC_CPU: begin
                mem_we    = cpu_we;
                mem_addr  = cpu_addr;
                mem_wdata = cpu_wdata;
            end
            SRC_DRAW: begin
                mem_we    = 1'b1;
                mem_addr  = back_base + drw_off;
                mem_wdata = drw_wdata;
            end
            default: mem_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/fb_store_arbiter.sv
// Module: fb_store_arbiter (top)
// Shares one frame store port among the display read-out, a processor and
// a drawing engine, and manages front/back buffer selection.
// Assumes: one transaction per cycle when mem_ready is high; grants are
// combinational and valid only in the cycle they are given.
module fb_store_arbiter
    import fsa_pkg::*;
#(
    parameter int              ADDR_W = 20,
    parameter int              DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE0 = 20'h00000,
    parameter logic [ADDR_W-1:0] BASE1 = 20'h4B000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              disp_req,
    input  logic [ADDR_W-1:0] disp_off,
    output logic              disp_gnt,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_gnt,
    input  logic              drw_req,
    input  logic [ADDR_W-1:0] drw_off,
    input  logic [DATA_W-1:0] drw_wdata,
    output logic              drw_gnt,
    input  logic              vblank,
    input  logic              swap_req,
    output logic              swap_done,
    output logic              front_sel
);
    fsa_src_e          win;
    logic              last_draw_q;
    logic [ADDR_W-1:0] front_base;
    logic [ADDR_W-1:0] back_base;

    fsa_pick u_pick (
        .en        (rst_n),
        .rdy       (mem_ready),
        .disp_req  (disp_req),
        .cpu_req   (cpu_req),
        .drw_req   (drw_req),
        .last_draw (last_draw_q),
        .win       (win)
    );

    fsa_bufswap u_swap (
        .clk       (clk),
        .rst_n     (rst_n),
        .vblank    (vblank),
        .swap_req  (swap_req),
        .front_sel (front_sel),
        .swap_done (swap_done)
    );

    // Base selection from the front-buffer flag
    always_comb begin
        front_base = front_sel ? BASE1 : BASE0;
        back_base  = front_sel ? BASE0 : BASE1;
    end

    // Grant decode from the winner
    always_comb begin
        disp_gnt = (win == SRC_DISP);
        cpu_gnt  = (win == SRC_CPU);
        drw_gnt  = (win == SRC_DRAW);
    end

    // Round-robin memory: which background master was served last
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_draw_q <= 1'b1;
        else if (cpu_gnt)
            last_draw_q <= 1'b0;
        else if (drw_gnt)
            last_draw_q <= 1'b1;
    end

    fsa_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
        .win        (win),
        .front_base (front_base),
        .back_base  (back_base),
        .disp_off   (disp_off),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .drw_off    (drw_off),
        .drw_wdata  (drw_wdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );
endmodule

// File: rtl/fsa_checker.sv
// Module: fsa_checker
// Property checks on the arbiter ports, attached by bind below.
// Assumes: synchronous active-low reset; all checks disabled in reset.
module fsa_checker (
    input logic clk,
    input logic rst_n,
    input logic mem_ready,
    input logic disp_req,
    input logic cpu_req,
    input logic drw_req,
    input logic disp_gnt,
    input logic cpu_gnt,
    input logic drw_gnt,
    input logic swap_done,
    input logic front_sel
);
    AST_DISP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ready && disp_req) |-> disp_gnt);                            // R1
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({disp_gnt, cpu_gnt, drw_gnt}));                          // R2
    AST_NO_GNT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready |-> !(disp_gnt || cpu_gnt || drw_gnt));                // R2
    AST_RR_CPU_THEN_DRW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ready && !disp_req && cpu_req && drw_req && $past(cpu_gnt)) |-> drw_gnt); // R4
    AST_RR_DRW_THEN_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ready && !disp_req && cpu_req && drw_req && $past(drw_gnt)) |-> cpu_gnt); // R4
    AST_FRONT_ONLY_ON_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(front_sel) |-> swap_done);                               // R8
    AST_DONE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |-> (front_sel != $past(front_sel)));                   // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |=> !swap_done);                                        // R9
endmodule

bind fb_store_arbiter fsa_checker u_fsa_checker (.*);

// File: tb/tb_fb_store_arbiter.sv
module tb_fb_store_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 32;
    localparam logic [AW-1:0] B0 = 20'h00000;
    localparam logic [AW-1:0] B1 = 20'h4B000;

    logic clk = 1'b0;
    logic rst_n;
    logic mem_ready, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic disp_req, disp_gnt, cpu_req, cpu_we, cpu_gnt, drw_req, drw_gnt;
    logic [AW-1:0] disp_off, cpu_addr, drw_off;
    logic [DW-1:0] cpu_wdata, drw_wdata;
    logic vblank, swap_req, swap_done, front_sel;

    int total = 0;
    int bad = 0;

    // model state
    logic m_front, m_done, m_pend, m_vbq, m_last_draw;

    always #(CLK_PERIOD/2) clk = ~clk;

    fb_store_arbiter #(.ADDR_W(AW), .DATA_W(DW), .BASE0(B0), .BASE1(B1)) dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // expected winner: 0 none, 1 disp, 2 cpu, 3 draw
    function automatic int exp_win(input logic rdy, input logic d, input logic c, input logic w, input logic last_draw);
        if (!rdy) return 0;
        if (d) return 1;
        if (c && w) return last_draw ? 2 : 3;
        if (c) return 2;
        if (w) return 3;
        return 0;
    endfunction

    // called at a negedge with inputs driven; checks, updates model, moves to next negedge
    task automatic step();
        int ew;
        string tag;
        logic [AW-1:0] ea;
        logic rise, now;
        #1;
        ew = exp_win(mem_ready, disp_req, cpu_req, drw_req, m_last_draw);
        if (!mem_ready) tag = "R2";
        else if (disp_req) tag = "R1";
        else if (cpu_req && drw_req) tag = "R4";
        else tag = "R3";
        chk(tag, {61'd0, disp_gnt, cpu_gnt, drw_gnt},
            {61'd0, ew == 1, ew == 2, ew == 3});
        chk("R2", {63'd0, mem_req}, {63'd0, ew != 0});
        if (ew == 1) begin
            ea = (m_front ? B1 : B0) + disp_off;
            chk("R5", {43'd0, mem_we, mem_addr}, {43'd0, 1'b0, ea});
        end else if (ew == 2) begin
            chk("R7", {11'd0, mem_we, mem_addr, mem_wdata}, {11'd0, cpu_we, cpu_addr, cpu_wdata});
        end else if (ew == 3) begin
            ea = (m_front ? B0 : B1) + drw_off;
            chk("R6", {11'd0, mem_we, mem_addr, mem_wdata}, {11'd0, 1'b1, ea, drw_wdata});
        end
        if (ew == 2) m_last_draw = 1'b0;
        if (ew == 3) m_last_draw = 1'b1;
        rise = vblank && !m_vbq;
        now = rise && (m_pend || swap_req);
        m_front = m_front ^ now;
        m_done = now;
        m_pend = (m_pend || swap_req) && !now;
        m_vbq = vblank;
        @(negedge clk);
        chk(m_done ? "R9" : "R8", {63'd0, front_sel}, {63'd0, m_front});
        chk(m_done ? "R9" : "R10", {63'd0, swap_done}, {63'd0, m_done});
    endtask

    task automatic randomize_inputs(input int p_ready, input int p_disp);
        mem_ready = ($urandom_range(99) < p_ready);
        disp_req = ($urandom_range(99) < p_disp);
        cpu_req = $urandom_range(1);
        drw_req = ($urandom_range(3) != 0);
        cpu_we = $urandom_range(1);
        disp_off = AW'($urandom);
        cpu_addr = AW'($urandom);
        drw_off = AW'($urandom);
        cpu_wdata = $urandom;
        drw_wdata = $urandom;
        swap_req = ($urandom_range(19) == 0);
        if ($urandom_range(15) == 0) vblank = !vblank;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic f0;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        mem_ready = 1'b1; disp_req = 1'b1; cpu_req = 1'b1; drw_req = 1'b1;
        cpu_we = 1'b0; disp_off = '0; cpu_addr = '0; drw_off = '0;
        cpu_wdata = '0; drw_wdata = '0; vblank = 1'b0; swap_req = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R11: grants held low in reset, swap state cleared
        chk("R11", {61'd0, disp_gnt, cpu_gnt, drw_gnt}, 64'd0);
        chk("R11", {62'd0, front_sel, swap_done}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        m_front = 1'b0; m_done = 1'b0; m_pend = 1'b0; m_vbq = 1'b0; m_last_draw = 1'b1;

        // R4: after reset both background masters tie, processor goes first
        disp_req = 1'b0;
        step();
        step();
        step();

        // random traffic, varied stall and display load
        for (int i = 0; i < 1500; i++) begin
            randomize_inputs(80, 30);
            step();
        end
        for (int i = 0; i < 1500; i++) begin
            randomize_inputs(40, 70);
            step();
        end

        // R10: request during high vblank waits for the next rising edge
        swap_req = 1'b0; vblank = 1'b0; step();
        vblank = 1'b1; step();
        f0 = front_sel;
        swap_req = 1'b1; step();
        swap_req = 1'b0;
        repeat (4) step();
        chk("R10", {63'd0, front_sel}, {63'd0, f0});
        vblank = 1'b0; step();
        vblank = 1'b1; step();
        chk("R9", {63'd0, front_sel}, {63'd0, !f0});
        // R10: rising edge with nothing pending leaves the selection alone
        vblank = 1'b0; step();
        vblank = 1'b1; step();
        chk("R10", {63'd0, front_sel}, {63'd0, !f0});
        // R9: request in the same cycle as the rising edge
        vblank = 1'b0; step();
        vblank = 1'b1; swap_req = 1'b1; step();
        swap_req = 1'b0;
        chk("R9", {63'd0, front_sel}, {63'd0, f0});
        step();

        // R2: stalled port with every master asking
        mem_ready = 1'b0; disp_req = 1'b1; cpu_req = 1'b1; drw_req = 1'b1;
        step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule